// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the raster timing for a video output. A horizontal pixel counter and a vertical line counter sweep the screen. From those counts and from a set of programmed timing values the block decodes horizontal sync, vertical sync and a blanking flag. In progressive scan the vertical total sets the frame height. In interlaced scan it sets the height of one field instead. The two field types then differ in height by one line, and a field flag reports which one is being drawn. In interlaced scan the vertical sync pulse can begin and end part way through a line, and the odd and even fields each have their own pixel positions for this.

A single asynchronous run control starts and stops the generator. It passes through a two-stage synchronizer into the pixel clock domain. While stopped, the counters are parked at line `v_total`, pixel 0. When the synchronized run level rises, the block issues a one-cycle `pipe_rst` pulse that clears the downstream display pipeline. Counting then begins from that parked position, so the first thing the screen sees is the end of a vertical blank period and its sync. All other timing inputs are used directly, with no resynchronization, and take effect at once.

Top module: `scan_timing_gen`

## Requirements
- R1: A change of `run_async` is seen through two synchronizer flops. A rise sampled at clock edge E0 makes `pipe_rst` high for exactly the one cycle that follows edge E0+2.
- R2: While stopped, the block holds `h_cnt`=0, `v_cnt`=`v_total` and `field_odd`=`ilace_en`, with `blank`=1, `hsync`=0 and `vsync`=0.
- R3: In the cycle where `pipe_rst` is high, the outputs show `h_cnt`=0 and `v_cnt`=`v_total`. Counting proceeds from there on every following edge.
- R4: While running, `h_cnt` steps by one per clock up to `h_total`. At that value (or above it) the next edge returns it to 0 and advances the line.
- R5: In progressive mode (`ilace_en`=0), `v_cnt` runs from 0 to `v_total` and then wraps to 0. `field_odd` stays 0.
- R6: In interlaced mode, `field_odd`=1 marks the odd field, which spans lines 0..`v_total`. The even field (`field_odd`=0) spans lines 0..`v_total`-1. `field_odd` inverts each time the line counter wraps to 0.
- R7: `hsync` is 1 exactly when running and `hs_start` <= `h_cnt` <= `hs_stop`.
- R8: `blank` is 1 when stopped, when `h_cnt` >= `h_active`, or when `v_cnt` >= `v_active`.
- R9: In progressive mode, `vsync` is high from pixel 0 of line `vs_first_line` through pixel `h_total` of line `vs_last_line`, both ends included.
- R10: In interlaced mode, `vsync` starts at pixel `*_vs_beg_px` of line `vs_first_line` and ends at pixel `*_vs_end_px` of line `vs_last_line`, both included. The odd pair applies when `field_odd`=1 and the even pair when it is 0.
- R11: Timing inputs other than `run_async` act with no register delay. A moved sync window changes `hsync` in the same cycle. A total lowered below the current count wraps that counter on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_async | input | 1 | Start (1) / stop (0) control, asynchronous to `clk` |
| ilace_en | input | 1 | Interlaced scan select |
| h_total | input | HW | Last pixel index of a line |
| h_active | input | HW | Number of visible pixels per line |
| hs_start | input | HW | First pixel of horizontal sync |
| hs_stop | input | HW | Last pixel of horizontal sync |
| v_total | input | VW | Last line index of a frame (progressive) or of the odd field |
| v_active | input | VW | Number of visible lines |
| vs_first_line | input | VW | Line on which vertical sync begins |
| vs_last_line | input | VW | Line on which vertical sync ends |
| odd_vs_beg_px | input | HW | Vertical sync start pixel, odd field |
| odd_vs_end_px | input | HW | Vertical sync end pixel, odd field |
| even_vs_beg_px | input | HW | Vertical sync start pixel, even field |
| even_vs_end_px | input | HW | Vertical sync end pixel, even field |
| h_cnt | output | HW | Current pixel index |
| v_cnt | output | VW | Current line index |
| field_odd | output | 1 | 1 while the odd field is drawn |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Outside the visible area, or stopped |
| pipe_rst | output | 1 | One-cycle pipeline reset at start |

## Verification
The assertions assume that the timing inputs meet a few conditions while the generator runs:
- `v_total` is at least 2.
- The sync windows are ordered and lie within the totals.
- The inputs stay steady during a run, except that a total may be lowered or a sync window moved.

Under those conditions, a change of the field flag can only come from a line wrap, and the counters never pass their limits. The stimulus draws every random configuration inside these ranges and reprograms registers only while the generator is stopped. The one deliberate live change is the directed case for R11, which moves the horizontal sync window and lowers `h_total`; the step and wrap properties are written to tolerate that change.

// File: rtl/tg_pkg.sv
package tg_pkg;

    typedef enum logic {
        FIELD_EVEN = 1'b0,
        FIELD_ODD  = 1'b1
    } field_e;

    // Line limit of the current field: the even field of an interlaced scan is one line shorter.
    function automatic logic last_line_short(input logic ilace, input field_e fld);
        return ilace && (fld == FIELD_EVEN);
    endfunction

endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic run,
    output logic start_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              run;
        logic              pulse;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.run   = st_q.chain[STAGES-1];
        st_d.pulse = st_q.chain[STAGES-1] & ~st_q.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run         = st_q.run;
    assign start_pulse = st_q.pulse;

endmodule

// File: rtl/tg_counter.sv
module tg_counter
    import tg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ilace,
    input  logic [HW-1:0] h_total,
    input  logic [VW-1:0] v_total,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output field_e        field
);
    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        field_e        fld;
    } cnt_t;

    cnt_t          st_d, st_q;
    logic [VW-1:0] v_last;

    always_comb begin
        st_d   = st_q;
        v_last = last_line_short(ilace, st_q.fld) ? v_total - 1'b1 : v_total;
        if (!run) begin
            st_d.h   = '0;
            st_d.v   = v_total;
            st_d.fld = ilace ? FIELD_ODD : FIELD_EVEN;
        end else if (st_q.h >= h_total) begin
            st_d.h = '0;
            if (st_q.v >= v_last) begin
                st_d.v = '0;
                if (ilace) begin
                    st_d.fld = field_e'(~st_q.fld);
                end
            end else begin
                st_d.v = st_q.v + 1'b1;
            end
        end else begin
            st_d.h = st_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{h: '0, v: '0, fld: FIELD_EVEN};
        end else begin
            st_q <= st_d;
        end
    end

    assign h_cnt = st_q.h;
    assign v_cnt = st_q.v;
    assign field = st_q.fld;

endmodule

// File: rtl/tg_decode.sv
module tg_decode
    import tg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          run,
    input  logic          ilace,
    input  field_e        field,
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    input  logic [HW-1:0] h_total,
    input  logic [HW-1:0] h_active,
    input  logic [HW-1:0] hs_start,
    input  logic [HW-1:0] hs_stop,
    input  logic [VW-1:0] v_active,
    input  logic [VW-1:0] vs_first_line,
    input  logic [VW-1:0] vs_last_line,
    input  logic [HW-1:0] odd_beg,
    input  logic [HW-1:0] odd_end,
    input  logic [HW-1:0] even_beg,
    input  logic [HW-1:0] even_end,
    output logic          hsync,
    output logic          vsync,
    output logic          blank
);
    logic [HW-1:0] beg_px, end_px;
    logic          past_begin, before_end;

    always_comb begin
        if (ilace) begin
            beg_px = (field == FIELD_ODD) ? odd_beg : even_beg;
            end_px = (field == FIELD_ODD) ? odd_end : even_end;
        end else begin
            beg_px = '0;
            end_px = h_total;
        end
        past_begin = (v_cnt > vs_first_line) || ((v_cnt == vs_first_line) && (h_cnt >= beg_px));
        before_end = (v_cnt < vs_last_line)  || ((v_cnt == vs_last_line)  && (h_cnt <= end_px));
        vsync      = run && past_begin && before_end;
        hsync      = run && (h_cnt >= hs_start) && (h_cnt <= hs_stop);
        blank      = !run || (h_cnt >= h_active) || (v_cnt >= v_active);
    end

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import tg_pkg::*;
#(
    parameter int HW          = 12,
    parameter int VW          = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_async,
    input  logic          ilace_en,
    input  logic [HW-1:0] h_total,
    input  logic [HW-1:0] h_active,
    input  logic [HW-1:0] hs_start,
    input  logic [HW-1:0] hs_stop,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] v_active,
    input  logic [VW-1:0] vs_first_line,
    input  logic [VW-1:0] vs_last_line,
    input  logic [HW-1:0] odd_vs_beg_px,
    input  logic [HW-1:0] odd_vs_end_px,
    input  logic [HW-1:0] even_vs_beg_px,
    input  logic [HW-1:0] even_vs_end_px,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          field_odd,
    output logic          hsync,
    output logic          vsync,
    output logic          blank,
    output logic          pipe_rst
);
    logic   run_w;
    field_e fld_w;

    tg_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (run_async),
        .run        (run_w),
        .start_pulse(pipe_rst)
    );

    tg_counter #(.HW(HW), .VW(VW)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_w),
        .ilace  (ilace_en),
        .h_total(h_total),
        .v_total(v_total),
        .h_cnt  (h_cnt),
        .v_cnt  (v_cnt),
        .field  (fld_w)
    );

    tg_decode #(.HW(HW), .VW(VW)) dec_i (
        .run          (run_w),
        .ilace        (ilace_en),
        .field        (fld_w),
        .h_cnt        (h_cnt),
        .v_cnt        (v_cnt),
        .h_total      (h_total),
        .h_active     (h_active),
        .hs_start     (hs_start),
        .hs_stop      (hs_stop),
        .v_active     (v_active),
        .vs_first_line(vs_first_line),
        .vs_last_line (vs_last_line),
        .odd_beg      (odd_vs_beg_px),
        .odd_end      (odd_vs_end_px),
        .even_beg     (even_vs_beg_px),
        .even_end     (even_vs_end_px),
        .hsync        (hsync),
        .vsync        (vsync),
        .blank        (blank)
    );

    assign field_odd = (fld_w == FIELD_ODD);

endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          pipe_rst,
    input logic          ilace,
    input logic          field_odd,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic [HW-1:0] h_total,
    input logic [VW-1:0] v_total,
    input logic          hsync,
    input logic          vsync,
    input logic          blank
);
    p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_rst |=> !pipe_rst);

    p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (blank && !hsync && !vsync));

    p_pulse_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_rst |-> (run && h_cnt == '0 && v_cnt == v_total));

    p_hstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h_cnt < h_total) |=> (h_cnt == $past(h_cnt) + 1'b1));

    p_hwrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h_cnt >= h_total) |=> (h_cnt == '0));

    p_vhold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h_cnt < h_total) |=> $stable(v_cnt));

    p_field_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(field_odd)) |-> (ilace && h_cnt == '0 && v_cnt == '0));

endmodule

bind scan_timing_gen tg_checker #(.HW(HW), .VW(VW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .pipe_rst (pipe_rst),
    .ilace    (ilace_en),
    .field_odd(field_odd),
    .h_cnt    (h_cnt),
    .v_cnt    (v_cnt),
    .h_total  (h_total),
    .v_total  (v_total),
    .hsync    (hsync),
    .vsync    (vsync),
    .blank    (blank)
);

// File: tb/scan_timing_gen_tb_top.sv
`timescale 1ns/1ps
module scan_timing_gen_tb_top;
    localparam int HW = 12;
    localparam int VW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run_async;
    logic          ilace_en;
    logic [HW-1:0] h_total, h_active, hs_start, hs_stop;
    logic [VW-1:0] v_total, v_active, vs_first_line, vs_last_line;
    logic [HW-1:0] odd_vs_beg_px, odd_vs_end_px, even_vs_beg_px, even_vs_end_px;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          field_odd, hsync, vsync, blank, pipe_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    scan_timing_gen #(.HW(HW), .VW(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_async(run_async), .ilace_en(ilace_en),
        .h_total(h_total), .h_active(h_active), .hs_start(hs_start), .hs_stop(hs_stop),
        .v_total(v_total), .v_active(v_active),
        .vs_first_line(vs_first_line), .vs_last_line(vs_last_line),
        .odd_vs_beg_px(odd_vs_beg_px), .odd_vs_end_px(odd_vs_end_px),
        .even_vs_beg_px(even_vs_beg_px), .even_vs_end_px(even_vs_end_px),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .field_odd(field_odd),
        .hsync(hsync), .vsync(vsync), .blank(blank), .pipe_rst(pipe_rst)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_hsync(input int h);
        return (h >= int'(hs_start)) && (h <= int'(hs_stop));
    endfunction

    function automatic bit exp_blank(input int h, input int v);
        return (h >= int'(h_active)) || (v >= int'(v_active));
    endfunction

    function automatic bit exp_vsync(input int h, input int v, input int f);
        int b, e;
        if (ilace_en) begin
            b = f ? int'(odd_vs_beg_px) : int'(even_vs_beg_px);
            e = f ? int'(odd_vs_end_px) : int'(even_vs_end_px);
        end else begin
            b = 0;
            e = int'(h_total);
        end
        return ((v > int'(vs_first_line)) || (v == int'(vs_first_line) && h >= b)) &&
               ((v < int'(vs_last_line))  || (v == int'(vs_last_line)  && h <= e));
    endfunction

    task automatic check_running(input int mh, input int mv, input int mf);
        chk("R4", "h_cnt", int'(h_cnt), mh);
        chk(ilace_en ? "R6" : "R5", "v_cnt", int'(v_cnt), mv);
        chk(ilace_en ? "R6" : "R5", "field_odd", int'(field_odd), mf);
        chk("R7", "hsync", int'(hsync), int'(exp_hsync(mh)));
        chk("R8", "blank", int'(blank), int'(exp_blank(mh, mv)));
        chk(ilace_en ? "R10" : "R9", "vsync", int'(vsync), int'(exp_vsync(mh, mv, mf)));
        chk("R1", "pipe_rst idle", int'(pipe_rst), 0);
    endtask

    task automatic check_stopped();
        chk("R2", "h_cnt", int'(h_cnt), 0);
        chk("R2", "v_cnt", int'(v_cnt), int'(v_total));
        chk("R2", "field_odd", int'(field_odd), int'(ilace_en));
        chk("R2", "blank", int'(blank), 1);
        chk("R2", "hsync", int'(hsync), 0);
        chk("R2", "vsync", int'(vsync), 0);
        chk("R2", "pipe_rst", int'(pipe_rst), 0);
    endtask

    // Starts the generator, tracks it for ncyc cycles against a bench model, then stops it.
    task automatic run_track(input int ncyc, input bit poke);
        int mh, mv, mf, lim;
        run_async = 1'b1;
        @(negedge clk);
        chk("R1", "pipe_rst after 1 edge", int'(pipe_rst), 0);
        @(negedge clk);
        chk("R1", "pipe_rst after 2 edges", int'(pipe_rst), 0);
        @(negedge clk);
        chk("R1", "pipe_rst after 3 edges", int'(pipe_rst), 1);
        chk("R3", "start h_cnt", int'(h_cnt), 0);
        chk("R3", "start v_cnt", int'(v_cnt), int'(v_total));
        mh = 0;
        mv = int'(v_total);
        mf = int'(ilace_en);
        for (int i = 0; i < ncyc; i++) begin
            if (mh >= int'(h_total)) begin
                mh  = 0;
                lim = (ilace_en && mf == 0) ? int'(v_total) - 1 : int'(v_total);
                if (mv >= lim) begin
                    mv = 0;
                    if (ilace_en) mf = 1 - mf;
                end else begin
                    mv = mv + 1;
                end
            end else begin
                mh = mh + 1;
            end
            @(negedge clk);
            check_running(mh, mv, mf);
            if (poke && i == 9) begin
                hs_start = HW'(mh);
                hs_stop  = HW'(mh);
                #1;
                chk("R11", "hsync after live window move", int'(hsync), 1);
                h_total = HW'(mh - 1);
            end
        end
        run_async = 1'b0;
        repeat (4) @(negedge clk);
        check_stopped();
    endtask

    task automatic set_cfg(input int ht, input int ha, input int hss, input int hse,
                           input int vt, input int va, input int vf, input int vl,
                           input int ob, input int oe, input int eb, input int ee,
                           input bit il);
        h_total = HW'(ht);  h_active = HW'(ha); hs_start = HW'(hss); hs_stop = HW'(hse);
        v_total = VW'(vt);  v_active = VW'(va); vs_first_line = VW'(vf); vs_last_line = VW'(vl);
        odd_vs_beg_px = HW'(ob); odd_vs_end_px = HW'(oe);
        even_vs_beg_px = HW'(eb); even_vs_end_px = HW'(ee);
        ilace_en = il;
    endtask

    initial begin
        int ht, ha, hss, hse, vt, va, vf, vl;
        void'($urandom(32'd2024));
        rst_n     = 1'b0;
        run_async = 1'b0;
        set_cfg(19, 15, 16, 17, 9, 7, 8, 9, 0, 19, 0, 19, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2", "reset pipe_rst", int'(pipe_rst), 0);
        chk("R2", "reset blank", int'(blank), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_stopped();

        // Progressive scan, several frames.
        run_track(3 * 20 * 10 + 7, 1'b0);

        // Interlaced scan with distinct mid-line vsync edges per field.
        ilace_en = 1'b1;
        repeat (2) @(negedge clk);
        set_cfg(23, 18, 19, 21, 8, 6, 7, 8, 12, 5, 3, 16, 1'b1);
        @(negedge clk);
        check_stopped();
        run_track(4 * 24 * 10 + 5, 1'b0);

        // Live register change while running.
        set_cfg(30, 24, 26, 28, 5, 4, 5, 5, 0, 30, 0, 30, 1'b0);
        repeat (2) @(negedge clk);
        run_track(200, 1'b1);

        // Constrained random configurations.
        for (int k = 0; k < 10; k++) begin
            ht  = 8 + int'($urandom % 33);
            ha  = 1 + int'($urandom % ht);
            hss = int'($urandom % (ht + 1));
            hse = hss + int'($urandom % (ht - hss + 1));
            vt  = 2 + int'($urandom % 11);
            va  = 1 + int'($urandom % vt);
            vf  = int'($urandom % (vt + 1));
            vl  = vf + int'($urandom % (vt - vf + 1));
            set_cfg(ht, ha, hss, hse, vt, va, vf, vl,
                    int'($urandom % (ht + 1)), int'($urandom % (ht + 1)),
                    int'($urandom % (ht + 1)), int'($urandom % (ht + 1)),
                    1'($urandom % 2));
            repeat (2) @(negedge clk);
            check_stopped();
            run_track(2 * (ht + 1) * (vt + 2) + 5, 1'b0);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule